// File: doc/BRIEF.md
# Dual-Convention Parallel Host Register Port

This block lets an external host processor reach four byte-wide registers over an 8-bit parallel bus. The same two control pins carry either of two strobe conventions. In one, separate active-low read-enable and write strobes are used. In the other, a read/write level is paired with an active-low data strobe. A strap input selects the convention. The strap is captured when the asynchronous active-low reset is released and is held until the next reset. Chip select is active low, and two address bits pick the register.

Host strobes cross into the block clock through a synchronizer. A host write takes effect when its strobe deasserts, using the address and data captured while the strobe was active. The data bus drives only while a chip-selected read is in progress. The interrupt request is an open-drain line. It is pulled low while the core holds an outgoing byte that the host has not read yet. On the core side there is a load strobe for outgoing bytes, and a full flag with a take strobe for incoming bytes.

Top module: `par_host_port`

## Requirements
- R1: While rst_n is low, data_oe and irq_oe are 0 whatever the host pins do. After reset, the status register (address 2) reads 0x00.
- R2: The strap is taken in the first clock after rst_n rises and is then held until the next reset. Value 0 selects the separate-strobe convention and 1 selects the level-plus-strobe convention.
- R3: In the separate-strobe convention, data_oe is 1 exactly while cs_n=0 and strobe_a (read enable, active low) is 0. data_out then shows the register at host_addr.
- R4: In the separate-strobe convention, a write through strobe_b (active low) stores the captured byte when strobe_b rises. Address 3 is a scratch register that reads back what was written.
- R5: In the level-plus-strobe convention, strobe_a high means read and strobe_a low means write, qualified by strobe_b (active low). Reads drive the bus, and writes commit when strobe_b rises.
- R6: With cs_n=1, strobe activity neither drives the bus nor changes any register.
- R7: A host write to address 1 sets core_rx_data to the byte and raises core_rx_full, which status bit 1 mirrors. core_rx_take clears the flag. A host write in the same cycle as core_rx_take wins.
- R8: core_tx_load stores core_tx_data in address 0 and sets the pending flag, which status bit 0 mirrors. While the flag is set, irq_oe is 1. irq_out is always 0.
- R9: A completed host read of address 0 clears the pending flag, which releases the interrupt line (irq_oe=0).
- R10: If core_tx_load falls in the same cycle as a completed host read of address 0, the flag stays set and address 0 holds the new byte.
- R11: Host writes to address 0 and address 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_style_strap | input | 1 | Convention strap, 0 separate strobes, 1 level plus strobe |
| cs_n | input | 1 | Active-low chip select |
| host_addr | input | 2 | Register select |
| strobe_a | input | 1 | Read enable (active low) or read/write level |
| strobe_b | input | 1 | Write strobe or data strobe, active low |
| data_in | input | 8 | Bus value seen from the host |
| data_out | output | 8 | Bus value driven to the host |
| data_oe | output | 1 | Bus drive enable |
| irq_out | output | 1 | Interrupt line value, constant 0 |
| irq_oe | output | 1 | Interrupt line pull-down enable |
| core_tx_load | input | 1 | Core loads an outgoing byte |
| core_tx_data | input | 8 | Outgoing byte |
| core_rx_take | input | 1 | Core consumes the incoming byte |
| core_rx_data | output | 8 | Last byte written by the host to address 1 |
| core_rx_full | output | 1 | Incoming byte waiting |

## Verification
Two updates can land on the pending flag in the same cycle: the clear from a finished host read of address 0 and a new core load. The bench releases the read enable on a falling clock edge. It counts the two synchronizer stages and the edge register, then pulses core_tx_load so that it lands exactly on the edge where the read completes. The result is judged at the ports: the interrupt enable must remain asserted, and a later read of address 0 must return the new byte. A matching collision between a host write to address 1 and core_rx_take is resolved in favour of the write.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic {
    BUS_SPLIT = 1'b0,
    BUS_LEVEL = 1'b1
  } bus_style_e;

  localparam logic [1:0] REG_TX   = 2'd0;
  localparam logic [1:0] REG_RX   = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_SCR  = 2'd3;

  // Read cycle active for the given convention and pin levels.
  function automatic logic host_is_read(bus_style_e st, logic csn, logic pa, logic pb);
    if (csn) return 1'b0;
    if (st == BUS_SPLIT) return !pa;
    return pa && !pb;
  endfunction

  // Write cycle active for the given convention and pin levels.
  function automatic logic host_is_write(bus_style_e st, logic csn, logic pa, logic pb);
    if (csn) return 1'b0;
    if (st == BUS_SPLIT) return !pb;
    return !pa && !pb;
  endfunction
endpackage

// File: rtl/hp_strobe_sync.sv
module hp_strobe_sync
  import hp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_valid,
  input  bus_style_e mode,
  input  logic       cs_n,
  input  logic       strobe_a,
  input  logic       strobe_b,
  output logic       rd_act,
  output logic       wr_act,
  output logic       rd_done,
  output logic       wr_done
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] stage [STAGES];
  logic [NPIN-1:0] synced;
  logic            rd_act_q, wr_act_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '1;
        else if (g == 0) stage[g] <= {cs_n, strobe_a, strobe_b};
        else stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign synced = stage[STAGES-1];
  assign rd_act = mode_valid && host_is_read(mode, synced[2], synced[1], synced[0]);
  assign wr_act = mode_valid && host_is_write(mode, synced[2], synced[1], synced[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
    end
  end

  assign rd_done = rd_act_q && !rd_act;
  assign wr_done = wr_act_q && !wr_act;
endmodule

// File: rtl/hp_regs.sv
module hp_regs
  import hp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_act,
  input  logic          wr_act,
  input  logic          rd_done,
  input  logic          wr_done,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          core_tx_load,
  input  logic [DW-1:0] core_tx_data,
  input  logic          core_rx_take,
  output logic [DW-1:0] rd_data,
  output logic          tx_pend,
  output logic          rx_full,
  output logic [DW-1:0] rx_data,
  output logic          tx_read_done,
  output logic          rx_write_done
);
  logic [AW-1:0] wr_addr_cap, rd_addr_cap;
  logic [DW-1:0] wr_data_cap, tx_data, scratch;
  logic [DW-1:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_cap <= '0;
      wr_data_cap <= '0;
      rd_addr_cap <= '0;
    end else begin
      if (wr_act) begin
        wr_addr_cap <= host_addr;
        wr_data_cap <= host_wdata;
      end
      if (rd_act) rd_addr_cap <= host_addr;
    end
  end

  assign tx_read_done  = rd_done && (rd_addr_cap == REG_TX);
  assign rx_write_done = wr_done && (wr_addr_cap == REG_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data <= '0;
      tx_pend <= 1'b0;
      rx_data <= '0;
      rx_full <= 1'b0;
      scratch <= '0;
    end else begin
      if (core_tx_load) begin
        tx_data <= core_tx_data;
        tx_pend <= 1'b1;
      end else if (tx_read_done) begin
        tx_pend <= 1'b0;
      end
      if (rx_write_done) begin
        rx_data <= wr_data_cap;
        rx_full <= 1'b1;
      end else if (core_rx_take) begin
        rx_full <= 1'b0;
      end
      if (wr_done && wr_addr_cap == REG_SCR) scratch <= wr_data_cap;
    end
  end

  always_comb begin
    status    = '0;
    status[0] = tx_pend;
    status[1] = rx_full;
    case (host_addr)
      REG_TX:   rd_data = tx_data;
      REG_RX:   rd_data = rx_data;
      REG_STAT: rd_data = status;
      default:  rd_data = scratch;
    endcase
  end
endmodule

// File: rtl/par_host_port.sv
module par_host_port
  import hp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_style_strap,
  input  logic          cs_n,
  input  logic [AW-1:0] host_addr,
  input  logic          strobe_a,
  input  logic          strobe_b,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          irq_out,
  output logic          irq_oe,
  input  logic          core_tx_load,
  input  logic [DW-1:0] core_tx_data,
  input  logic          core_rx_take,
  output logic [DW-1:0] core_rx_data,
  output logic          core_rx_full
);
  logic       mode_valid;
  bus_style_e mode_q;
  logic       rd_act, wr_act, rd_done, wr_done;
  logic       tx_pend, tx_read_done, rx_write_done;
  logic       host_read_now;

  // Strap capture on the first clock after reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_valid <= 1'b0;
      mode_q     <= BUS_SPLIT;
    end else if (!mode_valid) begin
      mode_valid <= 1'b1;
      mode_q     <= bus_style_e'(bus_style_strap);
    end
  end

  hp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .mode_valid(mode_valid), .mode(mode_q),
    .cs_n(cs_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .rd_act(rd_act), .wr_act(wr_act), .rd_done(rd_done), .wr_done(wr_done)
  );

  hp_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .wr_act(wr_act),
    .rd_done(rd_done), .wr_done(wr_done), .host_addr(host_addr),
    .host_wdata(data_in), .core_tx_load(core_tx_load),
    .core_tx_data(core_tx_data), .core_rx_take(core_rx_take),
    .rd_data(data_out), .tx_pend(tx_pend), .rx_full(core_rx_full),
    .rx_data(core_rx_data), .tx_read_done(tx_read_done),
    .rx_write_done(rx_write_done)
  );

  // Bus drive follows the raw pins so the host sees data within its strobe.
  assign host_read_now = mode_valid && host_is_read(mode_q, cs_n, strobe_a, strobe_b);
  assign data_oe       = rst_n && host_read_now;
  assign irq_oe        = rst_n && tx_pend;
  assign irq_out       = 1'b0;
endmodule

// File: rtl/hp_checker.sv
module hp_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic data_oe,
  input logic irq_oe,
  input logic mode_valid,
  input logic mode_q,
  input logic core_tx_load,
  input logic core_rx_take,
  input logic core_rx_full,
  input logic tx_read_done,
  input logic rx_write_done
);
  always_comb begin
    if (rst_n === 1'b0) begin
      // R1
      rst_quiet_chk: assert (!data_oe && !irq_oe);
    end
    if (cs_n === 1'b1) begin
      // R6
      no_select_no_drive_chk: assert (!data_oe);
    end
  end

  // R2
  strap_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |=> $stable(mode_q) && mode_valid);

  // R8
  load_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_tx_load |=> irq_oe);

  // R9
  read_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_read_done && !core_tx_load |=> !irq_oe);

  // R10
  load_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_read_done && core_tx_load |=> irq_oe);

  // R7
  take_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rx_take && !rx_write_done |=> !core_rx_full);

  // R7
  write_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_write_done |=> core_rx_full);
endmodule

bind par_host_port hp_checker u_hp_checker (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .data_oe(data_oe), .irq_oe(irq_oe),
  .mode_valid(mode_valid), .mode_q(mode_q), .core_tx_load(core_tx_load),
  .core_rx_take(core_rx_take), .core_rx_full(core_rx_full),
  .tx_read_done(tx_read_done), .rx_write_done(rx_write_done)
);

// File: tb/test_par_host_port.sv
module test_par_host_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       cs_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       pa = 1'b1;
  logic       pb = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       doe, irq_v, irq_en;
  logic       tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       rx_take = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full;
  int checks = 0;
  int errors = 0;
  bit level_mode = 1'b0;

  always #10 clk = ~clk;

  par_host_port i_par_host_port (
    .clk(clk), .rst_n(rst_n), .bus_style_strap(strap), .cs_n(cs_n),
    .host_addr(addr), .strobe_a(pa), .strobe_b(pb), .data_in(din),
    .data_out(dout), .data_oe(doe), .irq_out(irq_v), .irq_oe(irq_en),
    .core_tx_load(tx_load), .core_tx_data(tx_data), .core_rx_take(rx_take),
    .core_rx_data(rx_data), .core_rx_full(rx_full)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_pins();
    cs_n = 1'b1;
    pa   = 1'b1;
    pb   = 1'b1;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    strap = s;
    idle_pins();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    strap = ~s;
    level_mode = s;
    @(negedge clk);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
    @(negedge clk);
    cs_n = sel_n;
    addr = a;
    din  = d;
    if (level_mode) pa = 1'b0;
    @(negedge clk);
    pb = 1'b0;
    repeat (5) @(negedge clk);
    pb = 1'b1;
    repeat (5) @(negedge clk);
    idle_pins();
    @(negedge clk);
  endtask

  // Starts a read and leaves the strobe asserted.
  task automatic host_read_begin(input logic [1:0] a, input logic sel_n);
    @(negedge clk);
    cs_n = sel_n;
    addr = a;
    if (level_mode) begin
      pa = 1'b1;
      @(negedge clk);
      pb = 1'b0;
    end else begin
      pa = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic host_read_end();
    if (level_mode) pb = 1'b1;
    else pa = 1'b1;
    repeat (5) @(negedge clk);
    idle_pins();
    @(negedge clk);
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] v, input string req);
    host_read_begin(a, 1'b0);
    check(req, {7'd0, doe}, 8'h01);
    v = dout;
    host_read_end();
  endtask

  task automatic core_load(input logic [7:0] d);
    @(negedge clk);
    tx_load = 1'b1;
    tx_data = d;
    @(negedge clk);
    tx_load = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    rst_n = 1'b0;
    cs_n = 1'b0;
    pa = 1'b0;
    pb = 1'b1;
    tx_load = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {7'd0, doe}, 8'h00);
    check("R1 irq in reset", {7'd0, irq_en}, 8'h00);
    tx_load = 1'b0;
    do_reset(1'b0);
    host_read(2'd2, v, "R1 status read drive");
    check("R1 status after reset", v, 8'h00);
  endtask

  task automatic t_split_rw();
    logic [7:0] v;
    host_read_begin(2'd3, 1'b0);
    check("R3 drive during read", {7'd0, doe}, 8'h01);
    pa = 1'b1;
    #1;
    check("R3 release after read", {7'd0, doe}, 8'h00);
    pa = 1'b0;
    host_read_end();
    host_write(2'd3, 8'hA5, 1'b0);
    host_read(2'd3, v, "R4 drive");
    check("R4 scratch readback", v, 8'hA5);
    host_write(2'd3, 8'h5A, 1'b0);
    host_read(2'd3, v, "R4 drive");
    check("R4 scratch second value", v, 8'h5A);
  endtask

  task automatic t_deselect();
    logic [7:0] v;
    host_read_begin(2'd3, 1'b1);
    check("R6 no drive when deselected", {7'd0, doe}, 8'h00);
    host_read_end();
    host_write(2'd3, 8'hFF, 1'b1);
    host_read(2'd3, v, "R6 drive");
    check("R6 deselected write ignored", v, 8'h5A);
  endtask

  task automatic t_rx_path();
    logic [7:0] v;
    host_write(2'd1, 8'h3C, 1'b0);
    check("R7 rx data", rx_data, 8'h3C);
    check("R7 rx full", {7'd0, rx_full}, 8'h01);
    host_read(2'd2, v, "R7 drive");
    check("R7 status bit1", v, 8'h02);
    @(negedge clk);
    rx_take = 1'b1;
    @(negedge clk);
    rx_take = 1'b0;
    check("R7 take clears", {7'd0, rx_full}, 8'h00);
  endtask

  task automatic t_tx_path();
    logic [7:0] v;
    core_load(8'hA1);
    check("R8 irq enable", {7'd0, irq_en}, 8'h01);
    check("R8 irq level", {7'd0, irq_v}, 8'h00);
    host_read(2'd2, v, "R8 drive");
    check("R8 status bit0", v, 8'h01);
    host_write(2'd0, 8'h55, 1'b0);
    host_write(2'd2, 8'hFF, 1'b0);
    host_read(2'd2, v, "R11 drive");
    check("R11 status write ignored", v, 8'h01);
    check("R9 irq held before read", {7'd0, irq_en}, 8'h01);
    host_read(2'd0, v, "R9 drive");
    check("R11 tx write ignored", v, 8'hA1);
    check("R9 irq released", {7'd0, irq_en}, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    core_load(8'h11);
    host_read_begin(2'd0, 1'b0);
    if (level_mode) pb = 1'b1;
    else pa = 1'b1;
    // Two sync stages then the edge register: done acts on the third edge.
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_load = 1'b1;
    tx_data = 8'h22;
    @(negedge clk);
    tx_load = 1'b0;
    repeat (3) @(negedge clk);
    idle_pins();
    @(negedge clk);
    check("R10 flag kept", {7'd0, irq_en}, 8'h01);
    host_read(2'd0, v, "R10 drive");
    check("R10 new byte", v, 8'h22);
    check("R10 cleared by later read", {7'd0, irq_en}, 8'h00);
  endtask

  task automatic t_level_mode();
    logic [7:0] v;
    do_reset(1'b1);
    host_write(2'd3, 8'hC3, 1'b0);
    host_read(2'd3, v, "R5 drive");
    check("R5 scratch readback", v, 8'hC3);
    @(negedge clk);
    cs_n = 1'b0;
    pa = 1'b0;
    #1;
    check("R2 split read pin inert in level mode", {7'd0, doe}, 8'h00);
    idle_pins();
    host_write(2'd1, 8'h77, 1'b0);
    check("R5 rx write", rx_data, 8'h77);
    t_collision();
    do_reset(1'b0);
    host_write(2'd3, 8'h0F, 1'b0);
    host_read(2'd3, v, "R2 drive");
    check("R2 split mode after reset", v, 8'h0F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_split_rw();
    t_deselect();
    t_rx_path();
    t_tx_path();
    t_collision();
    t_level_mode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule